// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 32 interrupt inputs and drives one active-low request line toward a processor. Every input has its own priority (eight levels, 7 highest), trigger type and vector word. Software talks to the block through a simple register port. Each register access takes one cycle. Read data is combinational on the address.

Reading the vector register is the acknowledge. The read arbitrates among the qualifying inputs, returns the winner's vector, clears the winner's edge latch and pushes the winner's level and number onto an internal stack. Writing the end-of-interrupt register pops that stack. The request line is only raised for an input whose priority is strictly above the level on top of the stack, which makes nested service possible.

Input 0 never takes part in arbitration. It drives a separate active-low fast-interrupt output instead.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, both request outputs are high, the enable mask reads 0, the pending register reads 0 and the current-interrupt register (address 0x07) reads 0.
- R2: A mode register (address 0x40+n) holds the priority in bits [2:0] and the trigger type in bits [5:4], where 0 is high-level, 1 is low-level, 2 is rising-edge and 3 is falling-edge. A level input shows as pending two clocks after the pin changes. An edge input is latched as pending three clocks after the transition.
- R3: `irq_n` is low exactly when some input from 1 upward is pending and enabled and its priority is above the current level, or the stack is empty. A pending but disabled input never requests, yet its edge latch is still set.
- R4: A vector read (address 0x00) made while `irq_n` is low returns the vector word (address 0x80+n) of the highest-priority qualifying input, with the lowest number winning a tie. The read pushes that input's level and number. The stack never holds more than 8 entries.
- R5: The vector read clears the pending latch of the selected input only if that input is edge-triggered. A level input stays pending while its pin is active.
- R6: After a vector read, `irq_n` goes high unless another input with priority strictly above the new level is pending.
- R7: While an interrupt is in service, a newly pending input of strictly higher priority pulls `irq_n` low again.
- R8: A write to address 0x01 pops one stack entry and restores the level below it, or no level if the stack is now empty. The current-interrupt register reads bit 31 = stack not empty, bits [12:8] = top input number and bits [2:0] = top level. After a pop, `irq_n` falls for any qualifying input above the restored level, even one at or below the level just finished.
- R9: A vector read made while `irq_n` is high returns the spurious word (address 0x06) and leaves the stack unchanged. An end-of-interrupt write with an empty stack is ignored.
- R10: Input 0 drives `fiq_n` low when it is pending and enabled, with no arbitration. It never affects `irq_n` or the vector read. Its priority field is stored and reads back unchanged.
- R11: Writing a mask to address 0x05 clears the edge latches of the inputs whose bits are 1.
- R12: Writing a mask to address 0x02 sets enable bits, and writing a mask to address 0x03 clears them. Address 0x02 reads back the enable mask, and address 0x04 reads the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw interrupt inputs |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe; ignored when rd_en is high |
| addr | input | 8 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current address |
| irq_n | output | 1 | Active-low prioritized request |
| fiq_n | output | 1 | Active-low fast request from input 0 |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:

- **Equal-priority tie.** A wrong tie-break returns the higher-numbered vector.
- **Level input after acknowledge.** A design that clears it on the read loses the still-active request.
- **Equal priority during service.** A design that compares with "greater or equal" re-requests for an equal-priority input while in service.
- **Popping to an empty stack.** A design that compares against the finished level keeps `irq_n` high when the stack empties with only a lower input still pending.
- **Spurious reads.** A spurious read that pushes anyway shows up in the current-interrupt register.
- **Disabled inputs.** An input that is pending while disabled must still be latched and must not request.
- **Fast path.** Input 0 must stay out of the normal arbitration, and only the clear mask may drop its fast output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_VEC   = 8'h00;
  localparam logic [AW-1:0] A_EOI   = 8'h01;
  localparam logic [AW-1:0] A_ENSET = 8'h02;
  localparam logic [AW-1:0] A_ENCLR = 8'h03;
  localparam logic [AW-1:0] A_PEND  = 8'h04;
  localparam logic [AW-1:0] A_ICLR  = 8'h05;
  localparam logic [AW-1:0] A_SPUR  = 8'h06;
  localparam logic [AW-1:0] A_CUR   = 8'h07;
  localparam logic [1:0]    PG_MODE = 2'b01;
  localparam logic [1:0]    PG_VECT = 2'b10;

  typedef enum logic [1:0] {
    TRG_HIGH = 2'd0,
    TRG_LOW  = 2'd1,
    TRG_RISE = 2'd2,
    TRG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_sn = r2_q;
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  src_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic s1_q, s2_q, prv_q, lat_q;
  logic lat_d, rise, fall;

  always_comb begin
    rise  = s2_q & ~prv_q;
    fall  = ~s2_q & prv_q;
    lat_d = lat_q & ~clr_i;
    if (trig_i == TRG_RISE && rise) lat_d = 1'b1;
    if (trig_i == TRG_FALL && fall) lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      prv_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q  <= src_i;
      s2_q  <= s1_q;
      prv_q <= s2_q;
      lat_q <= lat_d;
    end
  end

  always_comb begin
    case (trig_i)
      TRG_HIGH: pend_o = s2_q;
      TRG_LOW:  pend_o = ~s2_q;
      default:  pend_o = lat_q;
    endcase
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int SW   = 5
) (
  input  logic [NSRC-1:0]    req_i,
  input  logic [NSRC*PW-1:0] prio_i,
  output logic               valid_o,
  output logic [SW-1:0]      idx_o,
  output logic [PW-1:0]      lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] >= lvl_o)) begin
        valid_o = 1'b1;
        idx_o   = SW'(i);
        lvl_o   = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  parameter int SW    = 5,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [PW-1:0]  push_lvl_i,
  input  logic [SW-1:0]  push_src_i,
  output logic           empty_o,
  output logic [PW-1:0]  top_lvl_o,
  output logic [SW-1:0]  top_src_o,
  output logic [SPW-1:0] sp_o
);
  logic [PW-1:0]  lvl_q [DEPTH];
  logic [SW-1:0]  src_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_d;
  logic           full, do_push, do_pop;
  logic [IW-1:0]  wr_idx, top_idx;

  assign full    = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !push_i && !empty_o;
  assign wr_idx  = IW'(sp_q);
  assign top_idx = IW'(sp_q - SPW'(1));

  always_comb begin
    sp_d = sp_q;
    if (do_push)     sp_d = sp_q + SPW'(1);
    else if (do_pop) sp_d = sp_q - SPW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lvl_q[i] <= '0;
        src_q[i] <= '0;
      end
    end else begin
      sp_q <= sp_d;
      if (do_push) begin
        lvl_q[wr_idx] <= push_lvl_i;
        src_q[wr_idx] <= push_src_i;
      end
    end
  end

  assign top_lvl_o = empty_o ? '0 : lvl_q[top_idx];
  assign top_src_o = empty_o ? '0 : src_q[top_idx];
  assign sp_o      = sp_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NPRIO = 8,
  parameter int DEPTH = NPRIO,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam int PW  = $clog2(NPRIO);
  localparam int SW  = $clog2(NSRC);
  localparam int SPW = $clog2(DEPTH + 1);

  logic                 rst_sn;
  logic [NSRC-1:0]      en_q, en_d;
  logic [PW-1:0]        prio_q [NSRC];
  trig_e                trig_q [NSRC];
  logic [DW-1:0]        vect_q [NSRC];
  logic [DW-1:0]        spur_q;
  logic [NSRC-1:0]      pend, clr, req;
  logic [NSRC*PW-1:0]   prio_flat;
  logic                 cand_v, qualify, ack, wr_ok, pop, iclr;
  logic                 stk_empty, in_rng, mode_we, vect_we;
  logic [SW-1:0]        cand_idx, top_src, idx;
  logic [PW-1:0]        cand_lvl, top_lvl;
  logic [SPW-1:0]       sp_w;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign idx     = addr[SW-1:0];
  assign in_rng  = int'(addr[5:0]) < NSRC;
  assign wr_ok   = wr_en && !rd_en;
  assign pop     = wr_ok && addr == A_EOI;
  assign iclr    = wr_ok && addr == A_ICLR;
  assign mode_we = wr_ok && addr[7:6] == PG_MODE && in_rng;
  assign vect_we = wr_ok && addr[7:6] == PG_VECT && in_rng;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign clr[g] = (ack && cand_idx == SW'(g) && trig_q[g][1]) ||
                      (iclr && wdata[g]);
      assign prio_flat[g*PW +: PW] = prio_q[g];
      irqc_src_cell u_cell (
        .clk(clk), .rst_n(rst_sn), .src_i(src_i[g]),
        .trig_i(trig_q[g]), .clr_i(clr[g]), .pend_o(pend[g])
      );
    end
  endgenerate

  assign req = pend & en_q & ~NSRC'(1);

  irqc_arb #(.NSRC(NSRC), .PW(PW), .SW(SW)) u_arb (
    .req_i(req), .prio_i(prio_flat),
    .valid_o(cand_v), .idx_o(cand_idx), .lvl_o(cand_lvl)
  );

  assign qualify = cand_v && (stk_empty || cand_lvl > top_lvl);
  assign ack     = rd_en && addr == A_VEC && qualify;

  irqc_stack #(.DEPTH(DEPTH), .PW(PW), .SW(SW)) u_stk (
    .clk(clk), .rst_n(rst_sn), .push_i(ack), .pop_i(pop),
    .push_lvl_i(cand_lvl), .push_src_i(cand_idx),
    .empty_o(stk_empty), .top_lvl_o(top_lvl), .top_src_o(top_src), .sp_o(sp_w)
  );

  always_comb begin
    en_d = en_q;
    if (wr_ok && addr == A_ENSET) en_d = en_q | wdata[NSRC-1:0];
    if (wr_ok && addr == A_ENCLR) en_d = en_q & ~wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      en_q   <= '0;
      spur_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= TRG_HIGH;
        vect_q[i] <= '0;
      end
    end else begin
      en_q <= en_d;
      if (wr_ok && addr == A_SPUR) spur_q <= wdata;
      if (mode_we) begin
        prio_q[idx] <= wdata[PW-1:0];
        trig_q[idx] <= trig_e'(wdata[5:4]);
      end
      if (vect_we) vect_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_VEC:   rdata = qualify ? vect_q[cand_idx] : spur_q;
      A_ENSET: rdata[NSRC-1:0] = en_q;
      A_PEND:  rdata[NSRC-1:0] = pend;
      A_SPUR:  rdata = spur_q;
      A_CUR: begin
        rdata[PW-1:0]  = top_lvl;
        rdata[8 +: SW] = top_src;
        rdata[DW-1]    = !stk_empty;
      end
      default: begin
        if (addr[7:6] == PG_MODE && in_rng) begin
          rdata[PW-1:0] = prio_q[idx];
          rdata[5:4]    = trig_q[idx];
        end else if (addr[7:6] == PG_VECT && in_rng) begin
          rdata = vect_q[idx];
        end
      end
    endcase
  end

  assign irq_n = !qualify;
  assign fiq_n = !(pend[0] && en_q[0]);
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int SPW   = 4,
  parameter int DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_en,
  input logic           wr_en,
  input logic [AW-1:0]  addr,
  input logic           irq_n,
  input logic           fiq_n,
  input logic [SPW-1:0] sp
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (irq_n && fiq_n && sp == '0)
        else $error("reset state violated");
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp) <= DEPTH);

  p_ack_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_VEC && !irq_n) |=> sp == $past(sp) + SPW'(1));

  p_spur_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_VEC && irq_n) |=> sp == $past(sp));

  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == A_EOI && sp != '0) |=> sp == $past(sp) - SPW'(1));

  p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == A_EOI && sp == '0) |=> sp == '0);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.SPW(SPW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .irq_n(irq_n), .fiq_n(fiq_n), .sp(sp_w)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, fiq_n;
  int total = 0, bad = 0;
  bit done = 0, live = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .fiq_n(fiq_n)
  );

  // behavioural reference
  bit [31:0]   m_en, m_edge, m_s1, m_s2, m_pv;
  int          m_prio [32];
  int          m_trig [32];
  logic [31:0] m_vec  [32];
  logic [31:0] m_spur;
  int          stk_l[$], stk_s[$];
  int          m_rs;

  function automatic bit m_pend(int i);
    if (m_trig[i] < 2) return m_s2[i] ^ (m_trig[i] == 1);
    return m_edge[i];
  endfunction

  function automatic int m_pick();
    int best = 0;
    for (int i = 1; i < 32; i++)
      if (m_pend(i) && m_en[i] && (best == 0 || m_prio[i] > m_prio[best])) best = i;
    return best;
  endfunction

  function automatic bit m_qual(int pk);
    if (pk == 0) return 0;
    if (stk_l.size() == 0) return 1;
    return m_prio[pk] > stk_l[stk_l.size()-1];
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r = '0;
    int pk;
    case (a)
      8'h00: begin pk = m_pick(); r = m_qual(pk) ? m_vec[pk] : m_spur; end
      8'h02: r = m_en;
      8'h04: for (int i = 0; i < 32; i++) r[i] = m_pend(i);
      8'h06: r = m_spur;
      8'h07: if (stk_l.size() > 0)
               r = 32'h8000_0000 | (stk_s[stk_s.size()-1] << 8) | stk_l[stk_l.size()-1];
      default: begin
        if (a[7:6] == 2'b01 && a[5:0] < 32) r = (m_trig[a[5:0]] << 4) | m_prio[a[5:0]];
        else if (a[7:6] == 2'b10 && a[5:0] < 32) r = m_vec[a[5:0]];
      end
    endcase
    return r;
  endfunction

  task automatic m_clear();
    m_en = '0; m_edge = '0; m_s1 = '0; m_s2 = '0; m_pv = '0; m_spur = '0;
    stk_l.delete(); stk_s.delete();
    for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; m_vec[i] = '0; end
  endtask

  task automatic m_step();
    int pk;
    bit [31:0] setm, clrm;
    pk = m_pick(); setm = '0; clrm = '0;
    for (int i = 0; i < 32; i++) begin
      if (m_trig[i] == 2 && m_s2[i] && !m_pv[i]) setm[i] = 1;
      if (m_trig[i] == 3 && !m_s2[i] && m_pv[i]) setm[i] = 1;
    end
    if (rd_en) begin
      if (addr == 8'h00 && m_qual(pk)) begin
        if (m_trig[pk] >= 2) clrm[pk] = 1;
        stk_l.push_back(m_prio[pk]); stk_s.push_back(pk);
      end
    end else if (wr_en) begin
      case (addr)
        8'h01: if (stk_l.size() > 0) begin void'(stk_l.pop_back()); void'(stk_s.pop_back()); end
        8'h02: m_en = m_en | wdata;
        8'h03: m_en = m_en & ~wdata;
        8'h05: clrm = clrm | wdata;
        8'h06: m_spur = wdata;
        default: begin
          if (addr[7:6] == 2'b01 && addr[5:0] < 32) begin
            m_prio[addr[5:0]] = wdata[2:0]; m_trig[addr[5:0]] = wdata[5:4];
          end else if (addr[7:6] == 2'b10 && addr[5:0] < 32) m_vec[addr[5:0]] = wdata;
        end
      endcase
    end
    m_edge = (m_edge & ~clrm) | setm;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = src;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rs = 0; m_clear(); end
    else if (m_rs < 2) m_rs++;
    else m_step();
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  // per-cycle comparison of both request outputs against the model
  always @(negedge clk) begin
    if (live) begin
      chk("R3 irq_n", {31'd0, irq_n}, {31'd0, !m_qual(m_pick())});
      chk("R10 fiq_n", {31'd0, fiq_n}, {31'd0, !(m_pend(0) && m_en[0])});
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string rq);
    @(negedge clk); rd_en = 1; addr = a;
    #1;
    chk(rq, rdata, exp);
    chk({rq, " model"}, rdata, m_read(a));
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(int i, bit v);
    @(negedge clk); src[i] = v;
  endtask

  initial begin
    src[9] = 1; src[12] = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 irq_n in sync reset", {31'd0, irq_n}, 32'd1);
    idle(3);
    live = 1;
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R1 fiq_n", {31'd0, fiq_n}, 32'd1);
    bus_rd(8'h02, 32'h0, "R1 enables");
    bus_rd(8'h07, 32'h0, "R1 current");
    // configuration
    bus_wr(8'h06, 32'h0000_0BAD);
    for (int i = 0; i < 32; i++) bus_wr(8'h80 + 8'(i), 32'h1000 + i);
    bus_wr(8'h43, 32'h02); bus_wr(8'h45, 32'h25); bus_wr(8'h47, 32'h25);
    bus_wr(8'h49, 32'h37); bus_wr(8'h4C, 32'h11); bus_wr(8'h40, 32'h26);
    bus_wr(8'h54, 32'h04);
    bus_rd(8'h40, 32'h26, "R10 prio readback");
    bus_rd(8'h49, 32'h37, "R2 mode readback");
    // disabled input, enable masks
    set_src(20, 1); idle(4);
    bus_rd(8'h04, 32'h0010_0000, "R12 pending");
    chk("R3 disabled no request", {31'd0, irq_n}, 32'd1);
    bus_wr(8'h02, 32'h0010_0000); idle(1);
    chk("R12 enable set", {31'd0, irq_n}, 32'd0);
    bus_wr(8'h03, 32'h0010_0000); idle(1);
    chk("R12 enable clear", {31'd0, irq_n}, 32'd1);
    set_src(20, 0);
    bus_wr(8'h02, 32'h0000_12A8);
    bus_rd(8'h02, 32'h0000_12A8, "R12 enable readback");
    // level latency and acknowledge
    set_src(3, 1);
    @(negedge clk); chk("R2 level one clock", {31'd0, irq_n}, 32'd1);
    @(negedge clk); chk("R2 level two clocks", {31'd0, irq_n}, 32'd0);
    bus_rd(8'h00, 32'h1003, "R4 vector");
    idle(1); chk("R6 drop after read", {31'd0, irq_n}, 32'd1);
    bus_rd(8'h07, 32'h8000_0302, "R8 current after push");
    bus_rd(8'h04, 32'h0000_0008, "R5 level stays pending");
    // equal-priority edges, nesting
    @(negedge clk); src[5] = 1; src[7] = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 edge two clocks", {31'd0, irq_n}, 32'd1);
    @(negedge clk); chk("R7 nest request", {31'd0, irq_n}, 32'd0);
    bus_rd(8'h00, 32'h1005, "R4 tie lower index");
    idle(1); chk("R6 equal level no request", {31'd0, irq_n}, 32'd1);
    bus_rd(8'h04, 32'h0000_0088, "R5 edge cleared");
    bus_wr(8'h01, 0); idle(1);
    chk("R8 reassert after pop", {31'd0, irq_n}, 32'd0);
    bus_rd(8'h07, 32'h8000_0302, "R8 restored level");
    bus_rd(8'h00, 32'h1007, "R4 second edge");
    bus_wr(8'h01, 0); idle(1);
    chk("R8 restored blocks equal", {31'd0, irq_n}, 32'd1);
    bus_wr(8'h01, 0); idle(1);
    chk("R8 empty reasserts lower", {31'd0, irq_n}, 32'd0);
    bus_rd(8'h07, 32'h0, "R8 empty current");
    bus_rd(8'h00, 32'h1003, "R4 level again");
    set_src(3, 0); src[5] = 0; src[7] = 0; idle(4);
    bus_wr(8'h01, 0);
    // spurious and empty pop
    bus_rd(8'h00, 32'h0BAD, "R9 spurious");
    bus_rd(8'h07, 32'h0, "R9 no push");
    bus_wr(8'h01, 0);
    bus_rd(8'h07, 32'h0, "R9 empty pop ignored");
    // low level and falling edge
    set_src(12, 0); idle(3);
    bus_rd(8'h00, 32'h100C, "R2 low level");
    set_src(12, 1); idle(4);
    bus_wr(8'h01, 0);
    set_src(9, 0); idle(4);
    bus_rd(8'h00, 32'h1009, "R2 falling edge");
    bus_rd(8'h04, 32'h0, "R5 falling cleared");
    bus_wr(8'h01, 0);
    // fast path
    bus_wr(8'h02, 32'h1);
    set_src(0, 1); idle(2); set_src(0, 0); idle(4);
    chk("R10 fiq asserted", {31'd0, fiq_n}, 32'd0);
    chk("R10 irq untouched", {31'd0, irq_n}, 32'd1);
    bus_rd(8'h00, 32'h0BAD, "R10 not arbitrated");
    bus_wr(8'h05, 32'h1); idle(1);
    chk("R11 fiq cleared", {31'd0, fiq_n}, 32'd1);
    // disabled edge latch, clear mask
    bus_wr(8'h03, 32'h20);
    set_src(5, 1); idle(5);
    chk("R3 disabled latched quiet", {31'd0, irq_n}, 32'd1);
    bus_rd(8'h04, 32'h20, "R3 latched while disabled");
    bus_wr(8'h02, 32'h20); idle(1);
    chk("R3 enable releases latch", {31'd0, irq_n}, 32'd0);
    bus_wr(8'h05, 32'h20); idle(1);
    chk("R11 clear mask", {31'd0, irq_n}, 32'd1);
    bus_rd(8'h04, 32'h0, "R11 pending cleared");
    set_src(5, 0); idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule